// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the program counter that addresses code memory and decides, once per cycle, where the next instruction comes from. On every clock edge the counter steps forward by one. It moves to a relative target instead when the sequencer requests an unconditional jump, or requests a conditional branch whose condition the current flags satisfy.

The relative target is the incremented counter plus a sign-extended two's-complement displacement. The displacement is therefore measured from the instruction after the jump or branch. Four condition codes cover the six branch spellings an assembler accepts, because equal and zero share one code and not-equal and not-zero share another. Conditions are judged from a zero flag and a negative flag that a compare stage outside this block supplies.

All counter arithmetic wraps modulo 2^PC_W. A synchronous reset returns the counter to address 0.

Top module: `pc_branch_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` is 0 after that edge, whatever the other inputs are.
- R2: With neither `jump_req` nor `branch_req` high, `pc` becomes `pc + 1` modulo 2^PC_W at each edge, so 255 is followed by 0 at the default width.
- R3: With `jump_req` high, `pc` becomes `pc + 1 + sext(offset)` modulo 2^PC_W, regardless of `cond_code`, `flag_zero` and `flag_neg`.
- R4: `offset` is two's complement. Its top bit set means a backward move: offset 8'hFE gives `pc - 1`, and offset 8'h80 gives `pc - 127`, both modulo 2^PC_W.
- R5: A branch with `cond_code` 2'b00 (equal / zero) is taken exactly when `flag_zero` is 1.
- R6: A branch with `cond_code` 2'b01 (not equal / not zero) is taken exactly when `flag_zero` is 0.
- R7: A branch with `cond_code` 2'b10 (greater) is taken exactly when `flag_zero` and `flag_neg` are both 0.
- R8: A branch with `cond_code` 2'b11 (greater or equal) is taken exactly when `flag_neg` is 0.
- R9: A taken branch moves `pc` to `pc + 1 + sext(offset)`. A branch that is not taken gives `pc + 1`, and its `offset` has no effect.
- R10: When `jump_req` and `branch_req` are both high, the jump is taken even if the branch condition fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| jump_req | input | 1 | Unconditional relative jump request for this cycle |
| branch_req | input | 1 | Conditional relative branch request for this cycle |
| cond_code | input | 2 | Branch condition: 00 eq/zero, 01 ne/nonzero, 10 greater, 11 greater-or-equal |
| offset | input | OFS_W | Two's-complement displacement, measured from the incremented counter |
| flag_zero | input | 1 | Zero flag from the last compare |
| flag_neg | input | 1 | Negative flag from the last compare |
| pc | output | PC_W | Current program counter |

## Verification
The bench builds the unit at its default widths: an 8-bit counter with an 8-bit displacement. At that size the counter wrap at 255 and the most negative displacement (-128) can be reached in a few cycles, and every flag combination can be tried against every condition code. The run also steers a branch with a large displacement whose condition fails, and raises a jump together with a failing branch. Near its end it applies reset while a jump is being requested.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    CC_EQ = 2'b00,
    CC_NE = 2'b01,
    CC_GT = 2'b10,
    CC_GE = 2'b11
  } cc_e;
endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval
  import pcu_pkg::*;
(
  input  logic [1:0] cc,
  input  logic       zf,
  input  logic       nf,
  output logic       holds
);
  cc_e code;
  assign code = cc_e'(cc);

  function automatic logic judge(input cc_e c, input logic z, input logic n);
    case (c)
      CC_EQ:   return z;
      CC_NE:   return !z;
      CC_GT:   return !z && !n;
      default: return !n;
    endcase
  endfunction

  always_comb holds = judge(code, zf, nf);
endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc #(
  parameter int PC_W  = 8,
  parameter int OFS_W = 8
) (
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [OFS_W-1:0] disp,
  input  logic             redirect,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  tgt_pc,
  output logic [PC_W-1:0]  nxt_pc
);
  function automatic logic [PC_W-1:0] widen(input logic [OFS_W-1:0] d);
    return PC_W'($signed(d));
  endfunction

  function automatic logic [PC_W-1:0] bump(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  always_comb begin
    seq_pc = bump(cur_pc);
    tgt_pc = seq_pc + widen(disp);
    nxt_pc = redirect ? tgt_pc : seq_pc;
  end
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int PC_W = 8,
  parameter logic [PC_W-1:0] START = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= START;
    else     q <= d;
  end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
  parameter int PC_W  = 8,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             jump_req,
  input  logic             branch_req,
  input  logic [1:0]       cond_code,
  input  logic [OFS_W-1:0] offset,
  input  logic             flag_zero,
  input  logic             flag_neg,
  output logic [PC_W-1:0]  pc
);
  logic            cond_ok;
  logic            branch_hit;
  logic            redirect;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] tgt_pc;
  logic [PC_W-1:0] nxt_pc;

  pcu_cond_eval u_cond (
    .cc    (cond_code),
    .zf    (flag_zero),
    .nf    (flag_neg),
    .holds (cond_ok)
  );

  assign branch_hit = branch_req && cond_ok;
  assign redirect   = jump_req || branch_hit;

  pcu_next_pc #(.PC_W(PC_W), .OFS_W(OFS_W)) u_next (
    .cur_pc   (pc),
    .disp     (offset),
    .redirect (redirect),
    .seq_pc   (seq_pc),
    .tgt_pc   (tgt_pc),
    .nxt_pc   (nxt_pc)
  );

  pcu_pc_reg #(.PC_W(PC_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt_pc),
    .q   (pc)
  );
endmodule

// File: rtl/pc_branch_unit_chk.sv
module pc_branch_unit_chk #(
  parameter int PC_W  = 8,
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             jump_req,
  input logic             branch_req,
  input logic [1:0]       cond_code,
  input logic [OFS_W-1:0] offset,
  input logic             flag_zero,
  input logic             flag_neg,
  input logic [PC_W-1:0]  pc,
  input logic             branch_hit,
  input logic             redirect
);
  function automatic logic [PC_W-1:0] dest(input logic [PC_W-1:0] p, input logic [OFS_W-1:0] d);
    return p + PC_W'(1) + PC_W'($signed(d));
  endfunction

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> pc == '0);

  assert_idle_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!jump_req && !branch_req) |=> pc == $past(pc) + PC_W'(1));

  assert_jump_target_R3: assert property (@(posedge clk) disable iff (rst)
    jump_req |=> pc == dest($past(pc), $past(offset)));

  assert_eq_taken_R5: assert property (@(posedge clk) disable iff (rst)
    (branch_req && !jump_req && cond_code == 2'b00 && flag_zero)
      |=> pc == dest($past(pc), $past(offset)));

  assert_ne_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (branch_req && !jump_req && cond_code == 2'b01 && !flag_zero)
      |=> pc == dest($past(pc), $past(offset)));

  assert_gt_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (branch_req && !jump_req && cond_code == 2'b10 && (flag_zero || flag_neg))
      |=> pc == $past(pc) + PC_W'(1));

  assert_ge_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (branch_req && !jump_req && cond_code == 2'b11 && flag_neg)
      |=> pc == $past(pc) + PC_W'(1));

  assert_hit_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    branch_hit |-> branch_req);

  assert_jump_wins_R10: assert property (@(posedge clk) disable iff (rst)
    jump_req |-> redirect);
endmodule

bind pc_branch_unit pc_branch_unit_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .jump_req   (jump_req),
  .branch_req (branch_req),
  .cond_code  (cond_code),
  .offset     (offset),
  .flag_zero  (flag_zero),
  .flag_neg   (flag_neg),
  .pc         (pc),
  .branch_hit (branch_hit),
  .redirect   (redirect)
);

// File: tb/pc_branch_unit_bench.sv
`timescale 1ns/1ps
module pc_branch_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 2000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       jump_req = 1'b0;
  logic       branch_req = 1'b0;
  logic [1:0] cond_code = 2'b00;
  logic [7:0] offset = 8'h00;
  logic       flag_zero = 1'b0;
  logic       flag_neg = 1'b0;
  logic [7:0] pc;

  int checks = 0;
  int errors = 0;
  int model_pc = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_branch_unit u_pc_branch_unit (
    .clk(clk), .rst(rst), .jump_req(jump_req), .branch_req(branch_req),
    .cond_code(cond_code), .offset(offset), .flag_zero(flag_zero),
    .flag_neg(flag_neg), .pc(pc)
  );

  // Monitor: compare one expected item per edge, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      int    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (int'(pc) != e) begin
        errors++;
        $display("FAIL %s pc=%0d expected=%0d", t, pc, e);
      end
    end
  end

  function automatic bit cond_true(input logic [1:0] cc, input logic z, input logic n);
    if (cc == 2'b00) return z == 1'b1;
    if (cc == 2'b01) return z == 1'b0;
    if (cc == 2'b10) return (z == 1'b0) && (n == 1'b0);
    return n == 1'b0;
  endfunction

  // Driver: apply one cycle of stimulus and push the expected pc
  task automatic step(input bit r, input bit j, input bit b, input logic [1:0] cc,
                      input logic [7:0] ofs, input bit z, input bit n, input string t);
    @(negedge clk);
    rst = r; jump_req = j; branch_req = b; cond_code = cc;
    offset = ofs; flag_zero = z; flag_neg = n;
    if (r) model_pc = 0;
    else if (j || (b && cond_true(cc, z, n))) begin
      int s;
      s = (ofs >= 8'd128) ? int'(ofs) - 256 : int'(ofs);
      model_pc = (model_pc + 1 + s + 512) % 256;
    end else model_pc = (model_pc + 1) % 256;
    exp_q.push_back(model_pc);
    tag_q.push_back(t);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 2'b00, 8'h00, 0, 0, "R1 reset");
    step(1, 1, 1, 2'b11, 8'h33, 0, 0, "R1 reset ignores requests");
    step(0, 0, 0, 2'b00, 8'h55, 1, 1, "R2 idle step");
    step(0, 0, 0, 2'b00, 8'h00, 0, 0, "R2 idle step");
    step(0, 0, 0, 2'b10, 8'hF0, 0, 0, "R2 idle step");
    step(0, 1, 0, 2'b00, 8'h05, 0, 1, "R3 jump forward");
    step(0, 1, 0, 2'b01, 8'h10, 1, 1, "R3 jump ignores flags");
    step(0, 1, 0, 2'b00, 8'hFE, 0, 0, "R4 jump -2 net -1");
    step(0, 1, 0, 2'b00, 8'h80, 0, 0, "R4 jump -128 wraps");
    step(0, 0, 1, 2'b00, 8'h04, 1, 0, "R5 eq taken");
    step(0, 0, 1, 2'b00, 8'h04, 0, 1, "R5 eq not taken");
    step(0, 0, 1, 2'b01, 8'h06, 0, 1, "R6 ne taken");
    step(0, 0, 1, 2'b01, 8'h06, 1, 0, "R6 ne not taken");
    step(0, 0, 1, 2'b10, 8'hFC, 0, 0, "R7 gt taken");
    step(0, 0, 1, 2'b10, 8'h20, 1, 0, "R7 gt blocked by zero");
    step(0, 0, 1, 2'b10, 8'h20, 0, 1, "R7 gt blocked by neg");
    step(0, 0, 1, 2'b11, 8'h08, 1, 0, "R8 ge taken on equal");
    step(0, 0, 1, 2'b11, 8'h08, 0, 0, "R8 ge taken on greater");
    step(0, 0, 1, 2'b11, 8'h08, 0, 1, "R8 ge not taken");
    step(0, 0, 1, 2'b00, 8'h7F, 0, 0, "R9 untaken offset ignored");
    step(0, 0, 1, 2'b10, 8'h81, 1, 1, "R9 untaken offset ignored");
    step(0, 1, 1, 2'b00, 8'h03, 0, 0, "R10 jump beats failing branch");
    step(0, 1, 1, 2'b11, 8'hF8, 0, 1, "R10 jump beats failing branch");
    // Steer to 254 then walk across the wrap
    while (model_pc != 250) step(0, 0, 0, 2'b00, 8'h00, 0, 0, "R2 walk");
    step(0, 1, 0, 2'b00, 8'h03, 0, 0, "R3 jump to 254");
    step(0, 0, 0, 2'b00, 8'h00, 0, 0, "R2 step to 255");
    step(0, 0, 0, 2'b00, 8'h00, 0, 0, "R2 wrap to 0");
    step(0, 1, 0, 2'b00, 8'hFD, 0, 0, "R4 backward wrap below 0");
    step(1, 1, 0, 2'b00, 8'h40, 0, 0, "R1 reset over jump");
    step(0, 0, 0, 2'b00, 8'h00, 0, 0, "R2 step after reset");
    @(negedge clk);
    rst = 1'b0; jump_req = 1'b0; branch_req = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule